// File: doc/BRIEF.md
# Scaled Index Effective Address Generator

This block turns a memory-referencing instruction into the byte address of its operand. It splits the instruction word into three fields: the indirect flag, the index selector and the word reference address. It adds an index value that has been shifted to fit the operand width, so a single index count selects the k-th byte, halfword, word or doubleword. It then clears the low address bits to the operand boundary. The instruction decoder supplies the operand-size class and a flag for opcodes that may not use indirection. The caller reads the selected index register and supplies its value along with the instruction.

When the indirect flag is set, the block asks for the memory word at the reference address over a request/response handshake. It replaces the reference address with the low bits of the returned word, and only then adds the index (post-indexing). Only one level of indirection is followed. The result is registered and marked with a one-cycle valid strobe. Addresses whose word part falls in the first sixteen words are flagged as general-register references, together with the register number.

Top module: `ea_gen`

## Requirements
- R1: The instruction word is 32 bits. Bit 31 is the indirect flag, bits 19:17 are the index selector, and bits 16:0 are the word reference address. Bits 30:20 do not affect the result.
- R2: When the index selector is 0, no index is added and the result is the reference address times four, aligned as in R5. Selector values 1 to 7 add the supplied index value.
- R3: The size code works as follows: 0 is byte, 1 is halfword, 2 is word and 3 is doubleword. The index value is shifted left by 0, 1, 2 or 3 places, in that order, before it is added.
- R4: The sum is taken modulo 2^19. Index bits that land above bit 18 are ignored. A negative two's-complement index gives a lower address, and word addresses wrap from 0x1FFFF to 0.
- R5: The result has 1, 2 or 3 low bits cleared for halfword, word or doubleword sizes. A byte address is left unaligned.
- R6: An indirect instruction raises a fetch request at the reference word address. Bits 16:0 of the returned word replace the reference address, and the index is then added to that pointer. Bits 31:17 of the returned word are ignored, and no second fetch is made.
- R7: When bits 18:2 of the result are below 16, the register-reference flag is set and the register number equals bits 5:2 of the result. Otherwise the flag is clear.
- R8: An indirect flag on an instruction marked as not allowing indirection sets the illegal flag. In that case no fetch is made and the result comes out the next cycle. The illegal flag is clear in all other cases.
- R9: The output valid lasts one cycle. It rises one cycle after the instruction is accepted (for a direct or illegal instruction) or one cycle after the fetch response is accepted.
- R10: The input ready signal is low while a fetch is outstanding. The fetch request and its address stay steady until the response arrives. A response presented while no fetch is outstanding has no effect.
- R11: After reset the output valid and the fetch request are low and the input ready signal is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can accept an instruction |
| in_instr | input | 32 | Instruction word |
| in_size | input | 2 | Operand size code |
| in_no_ind | input | 1 | Opcode class forbids indirection |
| in_xval | input | XV_W | Value of the selected index register |
| ind_req_valid | output | 1 | Indirect word fetch requested |
| ind_req_addr | output | WORD_AW | Word address to fetch |
| ind_rsp_valid | input | 1 | Fetched word present |
| ind_rsp_data | input | 32 | Fetched word |
| out_valid | output | 1 | Result strobe |
| out_ea | output | WORD_AW+2 | Effective byte address |
| out_reg_ref | output | 1 | Address selects a general register |
| out_reg_num | output | log2(REG_SPAN) | Register number |
| out_illegal | output | 1 | Forbidden indirection |

## Verification
A wrong scaling choice or a wrong saved index value shows as a wrong out_ea in the strobe cycle of the same instruction. Every size and selector combination is swept, so each such error is visible on the first vector that uses it. A stuck wait state shows within one cycle as in_ready held low, or as a fetch request that is missing or extra. A strobe that comes early or late is caught by sampling out_valid in exactly the cycle it should rise and in the cycle after.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int INSTR_W = 32;
    localparam int XSEL_W  = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } opsize_e;
endpackage

// File: rtl/ea_field_split.sv
module ea_field_split
    import ea_pkg::*;
#(
    parameter int WORD_AW = 17
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               ind,
    output logic [XSEL_W-1:0]  xsel,
    output logic [WORD_AW-1:0] refw
);
    logic unused_fields;

    assign ind  = instr[INSTR_W-1];
    assign xsel = instr[WORD_AW +: XSEL_W];
    assign refw = instr[WORD_AW-1:0];
    // opcode and register fields are decoded elsewhere
    assign unused_fields = ^instr[INSTR_W-2:WORD_AW+XSEL_W];
endmodule

// File: rtl/ea_scale_add.sv
module ea_scale_add #(
    parameter int WORD_AW = 17,
    parameter int XV_W    = 32
) (
    input  logic [WORD_AW-1:0] base_word,
    input  logic [XV_W-1:0]    xval,
    input  logic               use_idx,
    input  logic [1:0]         size,
    output logic [WORD_AW+1:0] ea
);
    localparam int BAW = WORD_AW + 2;
    localparam int XW3 = XV_W + 3;

    logic [BAW-1:0] scaled [4];
    logic [BAW-1:0] amask  [4];
    logic [BAW-1:0] disp;
    logic [BAW-1:0] sum;

    for (genvar s = 0; s < 4; s++) begin : g_size
        logic [XW3-1:0] wide;
        assign wide      = XW3'(xval) << s;
        assign scaled[s] = wide[BAW-1:0];
        assign amask[s]  = ~(BAW'((32'd1 << s) - 32'd1));
    end

    always_comb begin
        disp = use_idx ? scaled[size] : '0;
        sum  = {base_word, 2'b00} + disp;
        ea   = sum & amask[size];
    end
endmodule

// File: rtl/ea_reg_detect.sv
module ea_reg_detect #(
    parameter int WORD_AW  = 17,
    parameter int REG_SPAN = 16
) (
    input  logic [WORD_AW-1:0]          word_addr,
    output logic                        reg_ref,
    output logic [$clog2(REG_SPAN)-1:0] reg_num
);
    localparam int RN_W = $clog2(REG_SPAN);

    assign reg_ref = word_addr < WORD_AW'(REG_SPAN);
    assign reg_num = word_addr[RN_W-1:0];
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int WORD_AW  = 17,
    parameter int XV_W     = 32,
    parameter int REG_SPAN = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [INSTR_W-1:0]          in_instr,
    input  logic [1:0]                  in_size,
    input  logic                        in_no_ind,
    input  logic [XV_W-1:0]             in_xval,
    output logic                        ind_req_valid,
    output logic [WORD_AW-1:0]          ind_req_addr,
    input  logic                        ind_rsp_valid,
    input  logic [INSTR_W-1:0]          ind_rsp_data,
    output logic                        out_valid,
    output logic [WORD_AW+1:0]          out_ea,
    output logic                        out_reg_ref,
    output logic [$clog2(REG_SPAN)-1:0] out_reg_num,
    output logic                        out_illegal
);
    localparam int BAW = WORD_AW + 2;

    typedef struct packed {
        logic               wait_ind;
        opsize_e            size;
        logic               use_idx;
        logic [XV_W-1:0]    xval;
        logic [WORD_AW-1:0] ptr;
        logic               ov;
        logic [BAW-1:0]     ea;
        logic               ill;
    } st_t;

    st_t st_d, st_q;

    logic               f_ind;
    logic [XSEL_W-1:0]  f_xsel;
    logic [WORD_AW-1:0] f_ref;
    logic               accept, take_rsp;
    logic [WORD_AW-1:0] sa_base;
    logic [XV_W-1:0]    sa_xval;
    logic               sa_use;
    logic [1:0]         sa_size;
    logic [BAW-1:0]     sa_ea;
    logic               unused_rsp_hi;

    ea_field_split #(.WORD_AW(WORD_AW)) u_split (
        .instr (in_instr),
        .ind   (f_ind),
        .xsel  (f_xsel),
        .refw  (f_ref)
    );

    ea_scale_add #(.WORD_AW(WORD_AW), .XV_W(XV_W)) u_add (
        .base_word (sa_base),
        .xval      (sa_xval),
        .use_idx   (sa_use),
        .size      (sa_size),
        .ea        (sa_ea)
    );

    ea_reg_detect #(.WORD_AW(WORD_AW), .REG_SPAN(REG_SPAN)) u_reg (
        .word_addr (st_q.ea[BAW-1:2]),
        .reg_ref   (out_reg_ref),
        .reg_num   (out_reg_num)
    );

    assign unused_rsp_hi = ^ind_rsp_data[INSTR_W-1:WORD_AW];

    assign in_ready      = !st_q.wait_ind;
    assign accept        = in_valid && in_ready;
    assign take_rsp      = st_q.wait_ind && ind_rsp_valid;
    assign ind_req_valid = st_q.wait_ind;
    assign ind_req_addr  = st_q.ptr;
    assign out_valid     = st_q.ov;
    assign out_ea        = st_q.ea;
    assign out_illegal   = st_q.ill;

    always_comb begin
        // adder source: the fetched pointer while waiting, else the instruction
        if (st_q.wait_ind) begin
            sa_base = ind_rsp_data[WORD_AW-1:0];
            sa_xval = st_q.xval;
            sa_use  = st_q.use_idx;
            sa_size = st_q.size;
        end else begin
            sa_base = f_ref;
            sa_xval = in_xval;
            sa_use  = (f_xsel != '0);
            sa_size = in_size;
        end

        st_d    = st_q;
        st_d.ov = 1'b0;
        if (accept) begin
            if (f_ind && !in_no_ind) begin
                st_d.wait_ind = 1'b1;
                st_d.ptr      = f_ref;
                st_d.size     = opsize_e'(in_size);
                st_d.xval     = in_xval;
                st_d.use_idx  = (f_xsel != '0);
            end else begin
                st_d.ov  = 1'b1;
                st_d.ea  = sa_ea;
                st_d.ill = f_ind && in_no_ind;
            end
        end
        if (take_rsp) begin
            st_d.wait_ind = 1'b0;
            st_d.ov       = 1'b1;
            st_d.ea       = sa_ea;
            st_d.ill      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: without index the word part equals the reference address
    a_r2_no_index: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_instr[INSTR_W-1] &&
         in_instr[WORD_AW +: XSEL_W] == '0)
        |=> out_ea[BAW-1:3] == $past(in_instr[WORD_AW-1:1]));

    // R6: indirect request goes out at the reference word, no result yet
    a_r6_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_instr[INSTR_W-1] && !in_no_ind)
        |=> ind_req_valid && !out_valid &&
            ind_req_addr == $past(in_instr[WORD_AW-1:0]));

    // R6, R9: response ends the wait and yields the result next cycle
    a_r6_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req_valid && ind_rsp_valid) |=> out_valid && !ind_req_valid);

    // R8: forbidden indirection flagged with no fetch
    a_r8_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_instr[INSTR_W-1] && in_no_ind)
        |=> out_valid && out_illegal && !ind_req_valid);

    // R9: direct instruction result one cycle after acceptance
    a_r9_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_instr[INSTR_W-1])
        |=> out_valid && !out_illegal);

    // R10: outstanding request is held steady
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req_valid && !ind_rsp_valid)
        |=> ind_req_valid && $stable(ind_req_addr) && !in_ready);
endmodule

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;
    localparam int WORD_AW = 17;
    localparam int XV_W    = 32;
    localparam int BAW     = WORD_AW + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       in_instr = '0;
    logic [1:0]        in_size = '0;
    logic              in_no_ind = 1'b0;
    logic [XV_W-1:0]   in_xval = '0;
    logic              ind_req_valid;
    logic [WORD_AW-1:0] ind_req_addr;
    logic              ind_rsp_valid = 1'b0;
    logic [31:0]       ind_rsp_data = '0;
    logic              out_valid;
    logic [BAW-1:0]    out_ea;
    logic              out_reg_ref;
    logic [3:0]        out_reg_num;
    logic              out_illegal;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ea_gen u_dut (
        .clk, .rst_n, .in_valid, .in_ready, .in_instr, .in_size, .in_no_ind,
        .in_xval, .ind_req_valid, .ind_req_addr, .ind_rsp_valid, .ind_rsp_data,
        .out_valid, .out_ea, .out_reg_ref, .out_reg_num, .out_illegal
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [BAW-1:0] exp_ea(input logic [WORD_AW-1:0] base,
        input logic [2:0] x, input logic [31:0] xv, input logic [1:0] sz);
        logic [63:0] t;
        logic [BAW-1:0] m;
        t = {45'd0, base, 2'b00} + ((x != 0) ? ({32'd0, xv} << sz) : 64'd0);
        m = ~(BAW'((1 << sz) - 1));
        return t[BAW-1:0] & m;
    endfunction

    task automatic run_vec(input bit ind, input bit noind, input logic [1:0] sz,
                           input logic [2:0] x, input logic [WORD_AW-1:0] rf,
                           input logic [31:0] xv, input int lat);
        logic [WORD_AW-1:0] base;
        logic [BAW-1:0] e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_instr  = {ind, 7'h5A, 4'h3, x, rf};
        in_size   = sz;
        in_no_ind = noind;
        in_xval   = xv;
        chk(in_ready, "R10 ready when idle", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        in_xval  = 32'hDEAD_BEEF;
        base = rf;
        if (ind && !noind) begin
            base = ~rf;
            chk(ind_req_valid && !out_valid && ind_req_addr == rf,
                "R6 fetch address", 64'(ind_req_addr), 64'(rf));
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk(ind_req_valid && !in_ready && ind_req_addr == rf,
                    "R10 request held", 64'(ind_req_addr), 64'(rf));
            end
            ind_rsp_valid = 1'b1;
            ind_rsp_data  = {15'h6ABC, base};
            @(negedge clk);
            ind_rsp_valid = 1'b0;
        end
        e = exp_ea(base, x, xv, sz);
        // R1 R2 R3 R4 R5 R6: address value in the strobe cycle
        chk(out_valid, "R9 strobe", 64'(out_valid), 64'd1);
        chk(out_ea == e, "R3/R4/R5 address (R2 R6)", 64'(out_ea), 64'(e));
        chk(out_reg_ref == (e[BAW-1:2] < 16), "R7 register flag",
            64'(out_reg_ref), 64'(e[BAW-1:2] < 16));
        if (e[BAW-1:2] < 16)
            chk(out_reg_num == e[5:2], "R7 register number",
                64'(out_reg_num), 64'(e[5:2]));
        chk(out_illegal == (ind && noind), "R8 illegal flag",
            64'(out_illegal), 64'(ind && noind));
        chk(!ind_req_valid, "R8 no pending fetch", 64'(ind_req_valid), 64'd0);
        @(negedge clk);
        chk(!out_valid, "R9 one-cycle strobe", 64'(out_valid), 64'd0);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [WORD_AW-1:0] rfs [4];
        logic [31:0]        xvs [4];
        rfs[0] = 17'h00003; xvs[0] = 32'd5;
        rfs[1] = 17'h1FFFF; xvs[1] = 32'd1;
        rfs[2] = 17'h00100; xvs[2] = 32'hFFFF_FFFD;
        rfs[3] = 17'h0ABCD; xvs[3] = 32'h7FFF_FFF1;

        repeat (3) @(negedge clk);
        chk(!out_valid && !ind_req_valid && in_ready, "R11 reset state",
            {62'd0, out_valid, ind_req_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !ind_req_valid && in_ready, "R11 after release",
            {61'd0, out_valid, ind_req_valid, in_ready}, 64'd1);

        // R10: stray response while idle
        ind_rsp_valid = 1'b1;
        ind_rsp_data  = 32'h0000_0004;
        @(negedge clk);
        ind_rsp_valid = 1'b0;
        chk(!out_valid && !ind_req_valid && in_ready, "R10 stray response ignored",
            {62'd0, out_valid, ind_req_valid}, 64'd0);

        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 4; s++)
                for (int x = 0; x < 8; x++)
                    for (int m = 0; m < 4; m++)
                        run_vec(m[1], m[0], 2'(s), 3'(x), rfs[p], xvs[p], (x + s) % 3);

        // R1: opcode and register fields have no effect
        @(negedge clk);
        in_valid = 1'b1; in_instr = {1'b0, 11'h7FF, 3'd2, 17'h00010};
        in_size = 2'd2; in_no_ind = 1'b0; in_xval = 32'd3;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_ea == 19'h004C, "R1 other fields ignored",
            64'(out_ea), 64'h4C);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule